// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Interrupt Flags

This block belongs to a real-time clock. It handles the once-per-second update event. Each time the update strobe arrives, it marks that an update has ended. It also compares the current seconds, minutes and hours with three alarm bytes and marks an alarm hit when all three fields agree.

The block holds the resulting status as an 8-bit flag byte. It raises an active-high interrupt when a flag turns on for the first time while its enable is set. The interrupt is not raised again for a flag that is already on.

Software reads the flag byte through a read strobe. The read returns the current value and then clears every flag. It also drops the interrupt.

Alarm bytes can hold a wildcard code. The block accepts BCD or binary data. Hours in 12-hour format are normalised before they are compared.

Top module: `rtc_alarm_flags`

## Requirements
- R1: After reset the flag byte `flags_c` is 0x00 and `irq` is low.
- R2: An update strobe with `set_mode`=0 sets the update-ended flag (bit 4 of `flags_c`) on the following clock edge.
- R3: On such a strobe the alarm flag (bit 5) is set only when the seconds, minutes and hours all match. A mismatch in any one of the three fields leaves it clear.
- R4: An alarm byte whose bits 7 and 6 are both 1 matches any value of its field. A byte with only bit 7 set is compared normally.
- R5: With `bin_mode`=0, every field is converted from BCD (high nibble times ten plus low nibble) before the compare. With `bin_mode`=1, fields are compared as raw bytes. For example, a current value of 0x0A matches an alarm of 0x10 only in BCD mode.
- R6: With `hr24`=0, both hour bytes are reduced as follows before the compare: take bits 6:0, convert them, reduce modulo 12, and add 12 when bit 7 (PM) is set. With `hr24`=1, hour bytes are compared unchanged.
- R7: The interrupt flag (bit 7) and `irq` are set only when a flag that was clear becomes set and its enable is 1. `upd_ie` enables the update-ended flag and `alm_ie` enables the alarm flag.
- R8: During a read strobe, `flags_c` still shows the current value. After that clock edge the byte is 0x00 and `irq` is low.
- R9: While `set_mode`=1, update strobes are ignored and the flag byte does not change.
- R10: When a read strobe and an accepted update strobe fall on the same edge, the byte is cleared first and then the new flags are applied. The interrupt is therefore judged against the cleared state.
- R11: Bits 6 and 3:0 of `flags_c` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | One-cycle update event |
| rd_c_stb | input | 1 | One-cycle read of the flag byte (clears it) |
| set_mode | input | 1 | Time set in progress; blocks updates |
| alm_ie | input | 1 | Alarm interrupt enable |
| upd_ie | input | 1 | Update-ended interrupt enable |
| bin_mode | input | 1 | 1 = binary data, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| sec_now | input | 8 | Current seconds |
| min_now | input | 8 | Current minutes |
| hour_now | input | 8 | Current hours |
| sec_alm | input | 8 | Alarm seconds |
| min_alm | input | 8 | Alarm minutes |
| hour_alm | input | 8 | Alarm hours |
| flags_c | output | 8 | Flag byte: bit 7 interrupt, bit 5 alarm, bit 4 update-ended |
| irq | output | 1 | Interrupt line, active high |

## Verification
A wrong compare or a wrong data-format conversion appears in bit 5 of `flags_c` one clock after the strobe. The vector table therefore checks each format and wildcard case at exactly that cycle.

A flag that is stuck or held wrongly after a read shows up at the next read as a non-zero byte. A wrong new-edge test for the interrupt shows up as `irq` rising when a strobe hits a flag that is already set. Directed sequences set the flags up first, so that each of these errors is visible within one cycle.

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_stb,
  input  logic         rd_c_stb,
  input  logic         set_mode,
  input  logic         alm_ie,
  input  logic         upd_ie,
  input  logic         bin_mode,
  input  logic         hr24,
  input  logic [W-1:0] sec_now,
  input  logic [W-1:0] min_now,
  input  logic [W-1:0] hour_now,
  input  logic [W-1:0] sec_alm,
  input  logic [W-1:0] min_alm,
  input  logic [W-1:0] hour_alm,
  output logic [W-1:0] flags_c,
  output logic         irq
);
  localparam logic [W-1:0] TEN    = W'(10);
  localparam logic [W-1:0] TWELVE = W'(12);

  logic uf_q, af_q, irqf_q;

  function automatic logic [W-1:0] to_val(input logic [W-1:0] b, input logic bin);
    return bin ? b : (W'(b[7:4]) * TEN + W'(b[3:0]));
  endfunction

  function automatic logic [W-1:0] hour_val(input logic [W-1:0] b, input logic bin,
                                            input logic h24);
    logic [W-1:0] v;
    v = to_val({1'b0, b[6:0]}, bin);
    return h24 ? to_val(b, bin) : (v % TWELVE + (b[7] ? TWELVE : '0));
  endfunction

  wire sec_hit  = (&sec_alm[7:6])  || (to_val(sec_alm, bin_mode) == to_val(sec_now, bin_mode));
  wire min_hit  = (&min_alm[7:6])  || (to_val(min_alm, bin_mode) == to_val(min_now, bin_mode));
  wire hour_hit = (&hour_alm[7:6]) ||
                  (hour_val(hour_alm, bin_mode, hr24) == hour_val(hour_now, bin_mode, hr24));

  wire stb   = upd_stb & ~set_mode;
  wire alarm = stb & sec_hit & min_hit & hour_hit;

  wire uf_b   = uf_q   & ~rd_c_stb;
  wire af_b   = af_q   & ~rd_c_stb;
  wire irqf_b = irqf_q & ~rd_c_stb;

  wire fresh = (stb & ~uf_b & upd_ie) | (alarm & ~af_b & alm_ie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf_q   <= 1'b0;
      af_q   <= 1'b0;
      irqf_q <= 1'b0;
    end else begin
      uf_q   <= uf_b | stb;
      af_q   <= af_b | alarm;
      irqf_q <= irqf_b | fresh;
    end
  end

  assign flags_c = {irqf_q, 1'b0, af_q, uf_q, 4'b0000};
  assign irq     = irqf_q;

  AST_UF_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !set_mode) |=> flags_c[4]); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c_stb && !upd_stb) |=> (flags_c == '0 && !irq)); // R8
  AST_SET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !rd_c_stb) |=> $stable(flags_c)); // R9
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(upd_ie || alm_ie)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_stb && !rd_c_stb) |=> $stable(flags_c)); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_c[6] == 1'b0 && flags_c[3:0] == 4'b0)); // R11
endmodule

// File: tb/rtc_alarm_flags_test.sv
module rtc_alarm_flags_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_stb = 0, rd_c_stb = 0, set_mode = 0, alm_ie = 0, upd_ie = 0;
  logic bin_mode = 0, hr24 = 1;
  logic [7:0] sec_now = 0, min_now = 0, hour_now = 0;
  logic [7:0] sec_alm = 0, min_alm = 0, hour_alm = 0;
  logic [7:0] flags_c;
  logic irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rtc_alarm_flags uut (.clk, .rst_n, .upd_stb, .rd_c_stb, .set_mode, .alm_ie, .upd_ie,
    .bin_mode, .hr24, .sec_now, .min_now, .hour_now, .sec_alm, .min_alm, .hour_alm,
    .flags_c, .irq);

  // fields: bin, hr24, sec_now, min_now, hour_now, sec_alm, min_alm, hour_alm, expected alarm
  localparam int NV = 17;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0,1'b1,8'h30,8'h15,8'h13,8'h30,8'h15,8'h13,1'b1}, // R3 equal
    {1'b0,1'b1,8'h31,8'h15,8'h13,8'h30,8'h15,8'h13,1'b0}, // R3 sec
    {1'b0,1'b1,8'h30,8'h16,8'h13,8'h30,8'h15,8'h13,1'b0}, // R3 min
    {1'b0,1'b1,8'h30,8'h15,8'h14,8'h30,8'h15,8'h13,1'b0}, // R3 hour
    {1'b0,1'b1,8'h45,8'h15,8'h13,8'hC0,8'h15,8'h13,1'b1}, // R4 sec wild
    {1'b0,1'b1,8'h07,8'h59,8'h23,8'hFF,8'hC3,8'hC0,1'b1}, // R4 all wild
    {1'b0,1'b1,8'h00,8'h15,8'h13,8'h80,8'h15,8'h13,1'b0}, // R4 one bit only
    {1'b1,1'b1,8'h3B,8'h15,8'h13,8'h3B,8'h15,8'h13,1'b1}, // R5 binary equal
    {1'b0,1'b1,8'h0A,8'h15,8'h13,8'h10,8'h15,8'h13,1'b1}, // R5 bcd 0A=10
    {1'b1,1'b1,8'h0A,8'h15,8'h13,8'h10,8'h15,8'h13,1'b0}, // R5 binary 0A!=10
    {1'b0,1'b0,8'h00,8'h00,8'h92,8'h00,8'h00,8'h92,1'b1}, // R6 12 PM
    {1'b0,1'b0,8'h00,8'h00,8'h12,8'h00,8'h00,8'h00,1'b1}, // R6 12 AM = 0
    {1'b0,1'b0,8'h00,8'h00,8'h81,8'h00,8'h00,8'h01,1'b0}, // R6 PM differs
    {1'b0,1'b1,8'h00,8'h00,8'h12,8'h00,8'h00,8'h00,1'b0}, // R6 24h raw
    {1'b1,1'b0,8'h00,8'h00,8'h8C,8'h00,8'h00,8'h0C,1'b0}, // R6 bin 12PM vs 12AM
    {1'b1,1'b0,8'h00,8'h00,8'h8C,8'h00,8'h00,8'h80,1'b1}, // R6 bin 12PM = 0PM
    {1'b0,1'b0,8'h00,8'h00,8'h13,8'h00,8'h00,8'h01,1'b1}  // R6 13%12 = 1
  };

  task automatic check(input string req, input logic [7:0] exp_f, input logic exp_i);
    checks++;
    if (flags_c !== exp_f || irq !== exp_i) begin
      fails++;
      $display("FAIL %s flags=%02h irq=%b expected flags=%02h irq=%b", req, flags_c, irq, exp_f, exp_i);
    end
  endtask

  task automatic pulse(input logic u, input logic r);
    @(negedge clk); upd_stb = u; rd_c_stb = r;
    @(negedge clk); upd_stb = 0; rd_c_stb = 0;
  endtask

  task automatic match_all();
    sec_now = 8'h10; min_now = 8'h20; hour_now = 8'h05;
    sec_alm = 8'h10; min_alm = 8'h20; hour_alm = 8'h05;
    bin_mode = 0; hr24 = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      pulse(1'b0, 1'b1);
      {bin_mode, hr24, sec_now, min_now, hour_now, sec_alm, min_alm, hour_alm} = VEC[i][50:1];
      pulse(1'b1, 1'b0);
      check($sformatf("R2/R3/R11 vector %0d", i), VEC[i][0] ? 8'h30 : 8'h10, 1'b0);
    end

    // R7: update flag newly set with enable
    pulse(1'b0, 1'b1);
    sec_alm = 8'h01; sec_now = 8'h02; upd_ie = 1;
    pulse(1'b1, 1'b0);
    check("R7 update irq", 8'h90, 1'b1);
    // R8: value visible during read, cleared after
    @(negedge clk); rd_c_stb = 1;
    #1 check("R8 visible during read", 8'h90, 1'b1);
    @(negedge clk); rd_c_stb = 0;
    check("R8 cleared", 8'h00, 1'b0);

    // R7: already-set flag does not raise irq
    upd_ie = 0;
    pulse(1'b1, 1'b0);
    check("R7 no enable", 8'h10, 1'b0);
    upd_ie = 1;
    pulse(1'b1, 1'b0);
    check("R7 not newly set", 8'h10, 1'b0);

    // R7: alarm enable
    pulse(1'b0, 1'b1);
    upd_ie = 0; alm_ie = 1; match_all();
    pulse(1'b1, 1'b0);
    check("R7 alarm irq", 8'hB0, 1'b1);
    pulse(1'b0, 1'b1);
    sec_now = 8'h11;
    pulse(1'b1, 1'b0);
    check("R7 alarm enabled but no hit", 8'h10, 1'b0);

    // R9: set mode blocks strobes
    pulse(1'b0, 1'b1);
    set_mode = 1; upd_ie = 1; match_all();
    pulse(1'b1, 1'b0);
    check("R9 set blocks", 8'h00, 1'b0);
    set_mode = 0;

    // R10: read and update together
    upd_ie = 0; alm_ie = 0;
    pulse(1'b1, 1'b0);
    check("R10 setup", 8'h30, 1'b0);
    upd_ie = 1;
    pulse(1'b1, 1'b1);
    check("R10 collision", 8'hB0, 1'b1);

    // R1: reset mid-operation
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 reset clears", 8'h00, 1'b0);
    rst_n = 1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule